// File: doc/BRIEF.md
# Iterative Multiply Execute Sequencer

This block paces multiply-class operations in an in-order integer pipeline. Each operation loops through the execute stage a number of times that depends on its class. While the loop runs, the block holds the next instruction out of execute. It then announces on three separate strobes when the low result word, the high result word and the condition flags may be forwarded. The multiplier array is not part of the block. Only its pass count is modelled.

An operation is offered by raising `issue_i` for one cycle with a class code. The cycle in which it is accepted is called cycle 0. The first execute pass runs in cycle 1, and pass k runs in cycle k when nothing stalls. A pipeline stall (`stall_i`) freezes the loop and every pending strobe. The pass state machine has three states:

- IDLE: no operation is looping.
- LOOP: any pass except the last; `busy_o` is high.
- LAST: the final pass; `busy_o` is low, so a new operation may be accepted in this cycle.

Its transitions are:

- IDLE→LOOP: accept of a class with more than one pass.
- IDLE→LAST: accept of a one-pass class.
- LOOP→LAST: the second-to-last pass completes unstalled.
- LAST→IDLE: the last pass completes with no new accept.
- LAST→LOOP or LAST→LAST: back-to-back accept.

Pending strobes sit in per-strobe delay lines. They keep draining after the loop has ended, so they can overlap the next operation.

Top module: `mul_iter_seq`

## Requirements
- R1: Class code 0 (16-bit multiply, no accumulate) makes 1 pass; `lo_rdy_o` pulses in cycle 3. No other strobe fires.
- R2: Class code 1 (16-bit multiply-accumulate) makes 2 passes; `lo_rdy_o` pulses in cycle 3, right after execute.
- R3: Class code 2 (32-bit multiply or multiply-accumulate) makes 2 passes; `lo_rdy_o` pulses in cycle 4.
- R4: Class code 3 (flag-setting 32-bit multiply) makes 4 passes; `lo_rdy_o` pulses in cycle 4 and `flags_rdy_o` in cycle 5. The flags strobe never shares a cycle with a low-word strobe.
- R5: Class code 4 (64-bit long multiply) makes 3 passes; `lo_rdy_o` pulses in cycle 4 and `hi_rdy_o` in cycle 5.
- R6: Class code 5 (flag-setting long multiply) makes 5 passes; `lo_rdy_o` pulses in cycle 4, `hi_rdy_o` in cycle 5 and `flags_rdy_o` in cycle 6.
- R7: `busy_o` is high in cycles 1 to N-1 for an N-pass class, and low in the last pass. A new operation can be accepted in that last-pass cycle.
- R8: While `stall_i` is high, no strobe fires and the pass count and pending strobes hold. All later events slip by the number of stalled cycles.
- R9: An issue is ignored when `busy_o` is high, when `stall_i` is high, or when the class code is 6 or 7. An ignored issue causes no busy and no strobe.
- R10: `hi_rdy_o` fires only in the unstalled cycle after `lo_rdy_o` fired.
- R11: During and right after reset, all outputs are low and nothing is pending.
- R12: Strobes still owed by an operation keep their timing while a following operation loops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Offer an operation this cycle |
| op_class_i | input | 3 | Operation class code |
| stall_i | input | 1 | Pipeline stall; freezes the sequencer |
| busy_o | output | 1 | Execute occupied; hold the next instruction |
| lo_rdy_o | output | 1 | Low (or only) result word may be forwarded |
| hi_rdy_o | output | 1 | High word of a long result may be forwarded |
| flags_rdy_o | output | 1 | Condition flags have been written |

## Verification
Two functions can fall in the same cycle: the tail strobes of one operation, and the accept and looping of the next. An operation issued in the previous one's last pass starts its passes while the earlier `hi_rdy_o` and `flags_rdy_o` are still due. The directed sequences issue a second operation exactly in that cycle, sometimes with a stall laid across the overlap. Every cycle is judged against a bench model that counts unstalled cycles from each issue and applies the latency table in the requirements.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;

    localparam int CODE_W = 3;
    localparam int PASS_W = 3;
    localparam int SLOT_W = 3;
    localparam int N_LANES = 3;
    localparam int LANE_LO = 0;
    localparam int LANE_HI = 1;
    localparam int LANE_FLG = 2;

    localparam logic [CODE_W-1:0] CODE_H_MUL  = 3'd0;
    localparam logic [CODE_W-1:0] CODE_H_MAC  = 3'd1;
    localparam logic [CODE_W-1:0] CODE_W_MUL  = 3'd2;
    localparam logic [CODE_W-1:0] CODE_W_MULF = 3'd3;
    localparam logic [CODE_W-1:0] CODE_L_MUL  = 3'd4;
    localparam logic [CODE_W-1:0] CODE_L_MULF = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOP = 2'd1,
        ST_LAST = 2'd2
    } pass_state_e;

    // slot value 0 means the strobe is not produced for this class
    typedef struct packed {
        logic              legal;
        logic [PASS_W-1:0] passes;
        logic [SLOT_W-1:0] lo_slot;
        logic [SLOT_W-1:0] hi_slot;
        logic [SLOT_W-1:0] flg_slot;
    } op_prof_t;

endpackage

// File: rtl/mulseq_decode.sv
module mulseq_decode
    import mulseq_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output op_prof_t          prof_o
);

    always_comb begin
        prof_o = '0;
        unique case (code_i)
            CODE_H_MUL: begin
                prof_o.legal   = 1'b1;
                prof_o.passes  = 3'd1;
                prof_o.lo_slot = 3'd3;
            end
            CODE_H_MAC: begin
                prof_o.legal   = 1'b1;
                prof_o.passes  = 3'd2;
                prof_o.lo_slot = 3'd3;
            end
            CODE_W_MUL: begin
                prof_o.legal   = 1'b1;
                prof_o.passes  = 3'd2;
                prof_o.lo_slot = 3'd4;
            end
            CODE_W_MULF: begin
                prof_o.legal    = 1'b1;
                prof_o.passes   = 3'd4;
                prof_o.lo_slot  = 3'd4;
                prof_o.flg_slot = 3'd5;
            end
            CODE_L_MUL: begin
                prof_o.legal   = 1'b1;
                prof_o.passes  = 3'd3;
                prof_o.lo_slot = 3'd4;
                prof_o.hi_slot = 3'd5;
            end
            CODE_L_MULF: begin
                prof_o.legal    = 1'b1;
                prof_o.passes   = 3'd5;
                prof_o.lo_slot  = 3'd4;
                prof_o.hi_slot  = 3'd5;
                prof_o.flg_slot = 3'd6;
            end
            default: prof_o = '0;
        endcase
    end

endmodule

// File: rtl/mulseq_pass_fsm.sv
module mulseq_pass_fsm
    import mulseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic              stall_i,
    input  logic              legal_i,
    input  logic [PASS_W-1:0] passes_i,
    output logic              accept_o,
    output logic              busy_o
);

    pass_state_e       state_q, state_d;
    logic [PASS_W-1:0] left_q, left_d;

    // acceptance is open in every state except the looping one
    assign accept_o = issue_i && !stall_i && legal_i && (state_q != ST_LOOP);

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_o) begin
                    left_d  = passes_i;
                    state_d = (passes_i == 3'd1) ? ST_LAST : ST_LOOP;
                end
            end
            ST_LOOP: begin
                if (!stall_i) begin
                    left_d = left_q - 3'd1;
                    if (left_q == 3'd2) begin
                        state_d = ST_LAST;
                    end
                end
            end
            ST_LAST: begin
                if (!stall_i) begin
                    if (accept_o) begin
                        left_d  = passes_i;
                        state_d = (passes_i == 3'd1) ? ST_LAST : ST_LOOP;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        busy_o = 1'b0;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            ST_LOOP: busy_o = 1'b1;
            ST_LAST: busy_o = 1'b0;
            default: busy_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/mulseq_pulse_lane.sv
module mulseq_pulse_lane
    import mulseq_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic              load_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic              fire_o
);

    logic [DEPTH-1:0] pend_q;
    logic [DEPTH-1:0] ins;

    // a strobe due in cycle k after accept sits at index k-1 after the accept edge
    always_comb begin
        ins = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (load_i && (int'(slot_i) == i + 1)) begin
                ins[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (!stall_i) begin
            pend_q <= (pend_q >> 1) | ins;
        end
    end

    assign fire_o = pend_q[0] && !stall_i;

endmodule

// File: rtl/mul_iter_seq.sv
module mul_iter_seq
    import mulseq_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [CODE_W-1:0] op_class_i,
    input  logic              stall_i,
    output logic              busy_o,
    output logic              lo_rdy_o,
    output logic              hi_rdy_o,
    output logic              flags_rdy_o
);

    op_prof_t          prof;
    logic              accept;
    logic [SLOT_W-1:0] lane_slot [N_LANES];
    logic [N_LANES-1:0] lane_fire;

    mulseq_decode u_dec (
        .code_i (op_class_i),
        .prof_o (prof)
    );

    mulseq_pass_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_i  (issue_i),
        .stall_i  (stall_i),
        .legal_i  (prof.legal),
        .passes_i (prof.passes),
        .accept_o (accept),
        .busy_o   (busy_o)
    );

    assign lane_slot[LANE_LO]  = prof.lo_slot;
    assign lane_slot[LANE_HI]  = prof.hi_slot;
    assign lane_slot[LANE_FLG] = prof.flg_slot;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        mulseq_pulse_lane #(.DEPTH(DEPTH)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .stall_i (stall_i),
            .load_i  (accept),
            .slot_i  (lane_slot[g]),
            .fire_o  (lane_fire[g])
        );
    end

    assign lo_rdy_o    = lane_fire[LANE_LO];
    assign hi_rdy_o    = lane_fire[LANE_HI];
    assign flags_rdy_o = lane_fire[LANE_FLG];

endmodule

// File: rtl/mul_iter_seq_chk.sv
module mul_iter_seq_chk
    import mulseq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              issue_i,
    input logic [CODE_W-1:0] op_class_i,
    input logic              stall_i,
    input logic              busy_o,
    input logic              lo_rdy_o,
    input logic              hi_rdy_o,
    input logic              flags_rdy_o
);

    logic [2:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (!busy_o) begin
            busy_run <= '0;
        end else if (!stall_i && busy_run != 3'd7) begin
            busy_run <= busy_run + 3'd1;
        end
    end

    a_r8_quiet_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> !(lo_rdy_o || hi_rdy_o || flags_rdy_o));

    a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && busy_o) |=> busy_o);

    a_r10_hi_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rdy_o |-> ($past(lo_rdy_o) || $past(stall_i)));

    a_r9_busy_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(issue_i) && !$past(stall_i) && ($past(op_class_i) < 3'd6));

    a_r7_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !stall_i) |-> (busy_run < 3'd4));

    a_r4_flags_apart_from_lo: assert property (@(posedge clk) disable iff (!rst_n)
        flags_rdy_o |-> !lo_rdy_o);

    a_r11_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> !(busy_o || lo_rdy_o || hi_rdy_o || flags_rdy_o));

endmodule

bind mul_iter_seq mul_iter_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_i     (issue_i),
    .op_class_i  (op_class_i),
    .stall_i     (stall_i),
    .busy_o      (busy_o),
    .lo_rdy_o    (lo_rdy_o),
    .hi_rdy_o    (hi_rdy_o),
    .flags_rdy_o (flags_rdy_o)
);

// File: tb/mul_iter_seq_tb.sv
`timescale 1ns/1ps
module mul_iter_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue_i = 1'b0;
    logic [2:0] op_class_i = 3'd0;
    logic       stall_i = 1'b0;
    logic       busy_o, lo_rdy_o, hi_rdy_o, flags_rdy_o;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mul_iter_seq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_i     (issue_i),
        .op_class_i  (op_class_i),
        .stall_i     (stall_i),
        .busy_o      (busy_o),
        .lo_rdy_o    (lo_rdy_o),
        .hi_rdy_o    (hi_rdy_o),
        .flags_rdy_o (flags_rdy_o)
    );

    // latency table from the requirements: passes, low, high, flags (0 = none)
    task automatic table_of(input logic [2:0] c, output int n, output int lo,
                            output int hi, output int fl);
        n = 0; lo = 0; hi = 0; fl = 0;
        case (c)
            3'd0: begin n = 1; lo = 3; end
            3'd1: begin n = 2; lo = 3; end
            3'd2: begin n = 2; lo = 4; end
            3'd3: begin n = 4; lo = 4; fl = 5; end
            3'd4: begin n = 3; lo = 4; hi = 5; end
            3'd5: begin n = 5; lo = 4; hi = 5; fl = 6; end
            default: n = 0;
        endcase
    endtask

    // step reached in cycle c by an operation accepted in cycle t
    function automatic int step_at(int t, int c, logic [15:0] m);
        int s = 1;
        for (int k = t + 1; k < c; k++) if (!m[k]) s++;
        return s;
    endfunction

    task automatic model(input int t, input logic [2:0] cls, input int c,
                         input logic [15:0] m, inout logic [3:0] e);
        int n, lo, hi, fl, s;
        table_of(cls, n, lo, hi, fl);
        if (c > t && n > 0) begin
            s = step_at(t, c, m);
            if (s >= 1 && s <= n - 1) e[3] = 1'b1;
            if (!m[c] && lo != 0 && s == lo) e[2] = 1'b1;
            if (!m[c] && hi != 0 && s == hi) e[1] = 1'b1;
            if (!m[c] && fl != 0 && s == fl) e[0] = 1'b1;
        end
    endtask

    // drives issue A in cycle 0 and optional issue B in cycle tb, checks every cycle
    task automatic run_seq(input string req, input logic [2:0] ca, input int tb,
                           input logic [2:0] cb, input logic [15:0] m);
        int n, lo, hi, fl;
        bit a_ok, b_ok, a_busy;
        logic [3:0] e, act;
        table_of(ca, n, lo, hi, fl);
        a_ok = (n > 0) && !m[0];
        a_busy = 1'b0;
        if (a_ok && tb > 0) begin
            int s = step_at(0, tb, m);
            a_busy = (s >= 1 && s <= n - 1);
        end
        table_of(cb, n, lo, hi, fl);
        b_ok = (tb > 0) && (n > 0) && !m[tb] && !a_busy;
        for (int c = 0; c < 15; c++) begin
            @(negedge clk);
            issue_i    = (c == 0) || (c == tb);
            op_class_i = (c == 0) ? ca : cb;
            stall_i    = m[c];
            #1;
            e = 4'b0;
            if (a_ok) model(0, ca, c, m, e);
            if (b_ok) model(tb, cb, c, m, e);
            act = {busy_o, lo_rdy_o, hi_rdy_o, flags_rdy_o};
            n_checks++;
            if (act !== e) begin
                n_fail++;
                $display("FAIL %s cycle %0d busy/lo/hi/flg actual %b expected %b", req, c, act, e);
            end
        end
        issue_i = 1'b0;
        stall_i = 1'b0;
    endtask

    task automatic test_reset();
        #1;
        n_checks++;
        if ({busy_o, lo_rdy_o, hi_rdy_o, flags_rdy_o} !== 4'b0) begin
            n_fail++;
            $display("FAIL R11 in reset actual %b expected 0000",
                     {busy_o, lo_rdy_o, hi_rdy_o, flags_rdy_o});
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        n_checks++;
        if ({busy_o, lo_rdy_o, hi_rdy_o, flags_rdy_o} !== 4'b0) begin
            n_fail++;
            $display("FAIL R11 after reset actual %b expected 0000",
                     {busy_o, lo_rdy_o, hi_rdy_o, flags_rdy_o});
        end
    endtask

    task automatic test_classes();
        run_seq("R1",  3'd0, -1, 3'd0, 16'h0);
        run_seq("R2",  3'd1, -1, 3'd0, 16'h0);
        run_seq("R3",  3'd2, -1, 3'd0, 16'h0);
        run_seq("R4",  3'd3, -1, 3'd0, 16'h0);
        run_seq("R5",  3'd4, -1, 3'd0, 16'h0);
        run_seq("R6",  3'd5, -1, 3'd0, 16'h0);
    endtask

    task automatic test_busy_window();
        run_seq("R7 last-pass accept", 3'd3, 4, 3'd2, 16'h0);
        run_seq("R7 one-pass chain",   3'd0, 1, 3'd1, 16'h0);
    endtask

    task automatic test_stall();
        run_seq("R8 loop stall",   3'd3, -1, 3'd0, 16'b0000_0000_0000_1100);
        run_seq("R8 pulse stall",  3'd1, -1, 3'd0, 16'b0000_0000_0000_1000);
        run_seq("R10 split words", 3'd4, -1, 3'd0, 16'b0000_0000_0010_0000);
    endtask

    task automatic test_ignored();
        run_seq("R9 busy issue",   3'd3, 2, 3'd1, 16'h0);
        run_seq("R9 code 6",       3'd6, -1, 3'd0, 16'h0);
        run_seq("R9 code 7",       3'd7, -1, 3'd0, 16'h0);
        run_seq("R9 stalled issue", 3'd2, -1, 3'd0, 16'h0001);
    endtask

    task automatic test_overlap();
        run_seq("R12 tail overlap",  3'd5, 5, 3'd1, 16'h0);
        run_seq("R12 overlap stall", 3'd5, 5, 3'd4, 16'b0000_0000_0100_0000);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        test_reset();
        test_classes();
        test_busy_window();
        test_stall();
        test_ignored();
        test_overlap();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule